// File: doc/BRIEF.md
# Three-Bus Data Steering Buffer

This block sits between a 16-bit processor data bus, a 16-bit memory data bus and a 16-bit system data bus. It decides which bus drives which, one byte lane at a time. Direction inputs and active-low byte-lane enables are supplied separately for the processor side and the memory side. A lane-swap path lets an 8-bit peripheral on the system bus low lane exchange data with either byte of the processor bus. A capture register can hold a system low byte so that it is returned to the processor in place of the live value.

Each bidirectional bus is split into an input vector, an output vector and a per-lane output-enable pair. The pads or the surrounding fabric resolve the real wires. All control signals are primary inputs. The block does no arbitration, no wait-state generation and no decoding of bus cycles. Apart from the capture register, every path is combinational. The capture register works in the block clock domain and has a synchronous active-low reset.

Top module: `dsb_top`

## Requirements
- R1: While `rst_n` is low, all six output-enable bits are 0. After reset the capture register holds 0x00.
- R2: `cpu_oe[1]` (bits 15:8) is 1 exactly when `cpu_dir` is 0 and `cpu_en_hi_n` is 0. `cpu_oe[0]` (bits 7:0) is 1 exactly when `cpu_dir` is 0 and `cpu_en_lo_n` is 0.
- R3: A processor lane takes the memory lane's input when `mem_dir` is 1 and that memory lane's enable is 0. This takes priority over the system path.
- R4: In every other case, a processor lane takes the system-side value. With `cap_sel` 0 and no swap, that value is `sys_in` for the same lane.
- R5: On a clock edge where `cap_strobe` is 1 and was 0 at the previous edge, `sys_in[7:0]` is loaded into the capture register. At every other edge the register keeps its value.
- R6: With `cap_sel` 1, the capture register replaces the live `sys_in[7:0]` as the system low byte. The system high byte stays live.
- R7: With `swap_en_n` 0 and `swap_dir` 1 (read swap), the processor high lane takes the system low byte, after capture selection, whenever memory does not claim that lane.
- R8: `mem_out` equals `cpu_in`. `mem_oe[i]` is 1 exactly when `mem_dir` is 0 and memory lane i's enable is 0.
- R9: `sys_out[15:8]` equals `cpu_in[15:8]`. `sys_oe[i]` is 1 when `cpu_dir` is 1 and processor lane i's enable is 0.
- R10: With `swap_en_n` 0 and `swap_dir` 0 (write swap), `sys_out[7:0]` equals `cpu_in[15:8]`. In this case `sys_oe[0]` is 1 whenever `cpu_dir` is 1, even if `cpu_en_lo_n` is 1. Without the swap, `sys_out[7:0]` equals `cpu_in[7:0]`.
- R11: With `swap_en_n` 1, `swap_dir` has no effect on either output path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_dir | input | 1 | 0: block drives processor bus; 1: processor bus is a source |
| cpu_en_hi_n | input | 1 | Processor lane enable for bits 15:8, active low |
| cpu_en_lo_n | input | 1 | Processor lane enable for bits 7:0, active low |
| mem_dir | input | 1 | 1: memory read toward processor; 0: processor writes memory |
| mem_en_hi_n | input | 1 | Memory lane enable for bits 15:8, active low |
| mem_en_lo_n | input | 1 | Memory lane enable for bits 7:0, active low |
| swap_dir | input | 1 | 0: high byte to low lane (write); 1: low byte to high lane (read) |
| swap_en_n | input | 1 | Lane-swap enable, active low |
| cap_strobe | input | 1 | Capture request, acts on its rising edge |
| cap_sel | input | 1 | 1: use captured system low byte |
| cpu_in | input | 16 | Processor bus as seen by the block |
| cpu_out | output | 16 | Value driven onto processor bus |
| cpu_oe | output | 2 | Processor bus lane drive enables |
| mem_in | input | 16 | Memory bus as seen by the block |
| mem_out | output | 16 | Value driven onto memory bus |
| mem_oe | output | 2 | Memory bus lane drive enables |
| sys_in | input | 16 | System bus as seen by the block |
| sys_out | output | 16 | Value driven onto system bus |
| sys_oe | output | 2 | System bus lane drive enables |

## Verification
The hardest case to reach is a processor read in which the returned low byte is no longer on the system bus. The value must come from the capture register while the live bus already carries something else. The bench creates a strobe edge with one pattern on `sys_in`, then changes `sys_in` before it reads. It also keeps the strobe high across another edge and later lowers it, so it can show that only the rising edge loads the register. A read swap combined with the captured byte, and a memory lane claiming one lane while the other lane comes from the system side, are each set up as their own directed case.

// File: rtl/dsb_pkg.sv
// Package for the data steering buffer: shared lane count and swap encoding.
// Assumes a two-lane bus; the lane width is a parameter of each module.
package dsb_pkg;
    localparam int unsigned LANES = 2;

    // Meaning of the swap direction input.
    typedef enum logic {
        SWAP_HI_TO_LO = 1'b0,
        SWAP_LO_TO_HI = 1'b1
    } swap_dir_e;
endpackage

// File: rtl/dsb_read_latch.sv
// Capture register for the system low byte.
// Samples the strobe in the clock domain and loads on a detected 0->1 step.
// Assumes the strobe is synchronous to clk or already synchronised.
module dsb_read_latch #(
    parameter int unsigned LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [LANE_W-1:0] sys_lo,
    output logic [LANE_W-1:0] latch_q
);
    logic strobe_q;
    logic load;

    // Detect the rising step of the strobe.
    assign load = strobe & ~strobe_q;

    // Remember the strobe level and load the captured byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            latch_q  <= '0;
        end else begin
            strobe_q <= strobe;
            if (load) latch_q <= sys_lo;
        end
    end

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !strobe_q) |=> (latch_q == $past(sys_lo)));           // R5
    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && !strobe_q) |=> $stable(latch_q));                    // R5
endmodule

// File: rtl/dsb_cpu_mux.sv
// Source selection for the processor bus, lane by lane.
// A memory lane enabled for reading wins. Otherwise the system view is used:
// the low byte is either live or captured, and the high lane can take that
// low byte when the read swap is active. Lane drive follows the processor
// direction and enables.
module dsb_cpu_mux #(
    parameter int unsigned LANE_W = 8,
    localparam int unsigned BUS_W = dsb_pkg::LANES * LANE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_dir,
    input  logic [dsb_pkg::LANES-1:0] cpu_en_n,
    input  logic                     mem_dir,
    input  logic [dsb_pkg::LANES-1:0] mem_en_n,
    input  logic                     swap_en_n,
    input  dsb_pkg::swap_dir_e       swap_dir,
    input  logic                     cap_sel,
    input  logic [LANE_W-1:0]        latch_q,
    input  logic [BUS_W-1:0]         mem_in,
    input  logic [BUS_W-1:0]         sys_in,
    output logic [BUS_W-1:0]         cpu_out,
    output logic [dsb_pkg::LANES-1:0] cpu_oe
);
    logic [LANE_W-1:0] sys_lo_eff;
    logic              swap_rd;

    // Choose live or captured system low byte.
    assign sys_lo_eff = cap_sel ? latch_q : sys_in[LANE_W-1:0];
    // Read swap is active when enabled and pointed low-to-high.
    assign swap_rd = ~swap_en_n & (swap_dir == dsb_pkg::SWAP_LO_TO_HI);

    for (genvar i = 0; i < dsb_pkg::LANES; i++) begin : g_lane
        logic [LANE_W-1:0] sys_view;
        logic              mem_claim;

        // System-side value seen by this lane.
        if (i == 1) begin : g_hi
            assign sys_view = swap_rd ? sys_lo_eff : sys_in[i*LANE_W +: LANE_W];
        end else begin : g_lo
            assign sys_view = sys_lo_eff;
        end

        // Memory claims the lane when it is read on this lane.
        assign mem_claim = mem_dir & ~mem_en_n[i];

        // Lane data and drive enable.
        assign cpu_out[i*LANE_W +: LANE_W] = mem_claim ? mem_in[i*LANE_W +: LANE_W] : sys_view;
        assign cpu_oe[i] = rst_n & ~cpu_dir & ~cpu_en_n[i];
    end

    AST_CPU_QUIET_WHEN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_dir |-> (cpu_oe == '0));                                     // R2
    AST_MEM_WINS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dir && !mem_en_n[0]) |-> (cpu_out[LANE_W-1:0] == mem_in[LANE_W-1:0])); // R3
    AST_READ_SWAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_rd && !(mem_dir && !mem_en_n[1]) && cap_sel)
            |-> (cpu_out[2*LANE_W-1:LANE_W] == latch_q));                // R7
endmodule

// File: rtl/dsb_out_path.sv
// Drive paths from the processor bus toward memory and system buses.
// Memory gets processor data when its direction is write. The system bus
// gets processor data when the processor is the source; a write swap copies
// the high byte onto the low lane and drives that lane.
module dsb_out_path #(
    parameter int unsigned LANE_W = 8,
    localparam int unsigned BUS_W = dsb_pkg::LANES * LANE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_dir,
    input  logic [dsb_pkg::LANES-1:0] cpu_en_n,
    input  logic                     mem_dir,
    input  logic [dsb_pkg::LANES-1:0] mem_en_n,
    input  logic                     swap_en_n,
    input  dsb_pkg::swap_dir_e       swap_dir,
    input  logic [BUS_W-1:0]         cpu_in,
    output logic [BUS_W-1:0]         mem_out,
    output logic [dsb_pkg::LANES-1:0] mem_oe,
    output logic [BUS_W-1:0]         sys_out,
    output logic [dsb_pkg::LANES-1:0] sys_oe
);
    logic swap_wr;

    // Write swap is active when enabled and pointed high-to-low.
    assign swap_wr = ~swap_en_n & (swap_dir == dsb_pkg::SWAP_HI_TO_LO);

    // Memory data is the processor bus unchanged.
    assign mem_out = cpu_in;

    for (genvar i = 0; i < dsb_pkg::LANES; i++) begin : g_lane
        // Memory lane drive when writing.
        assign mem_oe[i] = rst_n & ~mem_dir & ~mem_en_n[i];

        if (i == 0) begin : g_lo
            // Low lane: own byte, or high byte under write swap.
            assign sys_out[LANE_W-1:0] = swap_wr ? cpu_in[2*LANE_W-1:LANE_W]
                                                 : cpu_in[LANE_W-1:0];
            assign sys_oe[0] = rst_n & cpu_dir & (~cpu_en_n[0] | swap_wr);
        end else begin : g_up
            // Upper lanes pass straight through.
            assign sys_out[i*LANE_W +: LANE_W] = cpu_in[i*LANE_W +: LANE_W];
            assign sys_oe[i] = rst_n & cpu_dir & ~cpu_en_n[i];
        end
    end

    AST_MEM_QUIET_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dir |-> (mem_oe == '0));                                     // R8
    AST_WRITE_SWAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_dir && swap_wr) |-> (sys_oe[0] && sys_out[LANE_W-1:0] == cpu_in[2*LANE_W-1:LANE_W])); // R10
    AST_SYS_QUIET_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_dir |-> (sys_oe == '0));                                    // R9
endmodule

// File: rtl/dsb_top.sv
// Three-bus data steering buffer, top level.
// Packs the per-lane enable pins and wires the capture register, the
// processor-side selector and the outward drive paths. Assumes all controls
// come from an external bus-cycle decoder and are stable around clk edges.
module dsb_top #(
    parameter int unsigned LANE_W = 8,
    localparam int unsigned BUS_W = dsb_pkg::LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_dir,
    input  logic             cpu_en_hi_n,
    input  logic             cpu_en_lo_n,
    input  logic             mem_dir,
    input  logic             mem_en_hi_n,
    input  logic             mem_en_lo_n,
    input  logic             swap_dir,
    input  logic             swap_en_n,
    input  logic             cap_strobe,
    input  logic             cap_sel,
    input  logic [BUS_W-1:0] cpu_in,
    output logic [BUS_W-1:0] cpu_out,
    output logic [1:0]       cpu_oe,
    input  logic [BUS_W-1:0] mem_in,
    output logic [BUS_W-1:0] mem_out,
    output logic [1:0]       mem_oe,
    input  logic [BUS_W-1:0] sys_in,
    output logic [BUS_W-1:0] sys_out,
    output logic [1:0]       sys_oe
);
    logic [1:0]         cpu_en_n;
    logic [1:0]         mem_en_n;
    logic [LANE_W-1:0]  latch_q;
    dsb_pkg::swap_dir_e swap_d;

    // Gather lane enables, high lane at index 1.
    assign cpu_en_n = {cpu_en_hi_n, cpu_en_lo_n};
    assign mem_en_n = {mem_en_hi_n, mem_en_lo_n};
    assign swap_d   = dsb_pkg::swap_dir_e'(swap_dir);

    dsb_read_latch #(.LANE_W(LANE_W)) i_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (cap_strobe),
        .sys_lo  (sys_in[LANE_W-1:0]),
        .latch_q (latch_q)
    );

    dsb_cpu_mux #(.LANE_W(LANE_W)) i_cpu_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_dir   (cpu_dir),
        .cpu_en_n  (cpu_en_n),
        .mem_dir   (mem_dir),
        .mem_en_n  (mem_en_n),
        .swap_en_n (swap_en_n),
        .swap_dir  (swap_d),
        .cap_sel   (cap_sel),
        .latch_q   (latch_q),
        .mem_in    (mem_in),
        .sys_in    (sys_in),
        .cpu_out   (cpu_out),
        .cpu_oe    (cpu_oe)
    );

    dsb_out_path #(.LANE_W(LANE_W)) i_out_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_dir   (cpu_dir),
        .cpu_en_n  (cpu_en_n),
        .mem_dir   (mem_dir),
        .mem_en_n  (mem_en_n),
        .swap_en_n (swap_en_n),
        .swap_dir  (swap_d),
        .cpu_in    (cpu_in),
        .mem_out   (mem_out),
        .mem_oe    (mem_oe),
        .sys_out   (sys_out),
        .sys_oe    (sys_oe)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (cpu_oe == 2'b00 && mem_oe == 2'b00 && sys_oe == 2'b00)); // R1
    AST_NO_CPU_SYS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_oe & sys_oe) == 2'b00);                                     // R9
endmodule

// File: tb/test_dsb_top.sv
// Directed bench for dsb_top: one task per scenario, each checking its results.
module test_dsb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_dir, cpu_en_hi_n, cpu_en_lo_n;
    logic        mem_dir, mem_en_hi_n, mem_en_lo_n;
    logic        swap_dir, swap_en_n, cap_strobe, cap_sel;
    logic [15:0] cpu_in, mem_in, sys_in;
    logic [15:0] cpu_out, mem_out, sys_out;
    logic [1:0]  cpu_oe, mem_oe, sys_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dsb_top i_dsb_top (
        .clk(clk), .rst_n(rst_n),
        .cpu_dir(cpu_dir), .cpu_en_hi_n(cpu_en_hi_n), .cpu_en_lo_n(cpu_en_lo_n),
        .mem_dir(mem_dir), .mem_en_hi_n(mem_en_hi_n), .mem_en_lo_n(mem_en_lo_n),
        .swap_dir(swap_dir), .swap_en_n(swap_en_n),
        .cap_strobe(cap_strobe), .cap_sel(cap_sel),
        .cpu_in(cpu_in), .cpu_out(cpu_out), .cpu_oe(cpu_oe),
        .mem_in(mem_in), .mem_out(mem_out), .mem_oe(mem_oe),
        .sys_in(sys_in), .sys_out(sys_out), .sys_oe(sys_oe)
    );

    // Compare one value and count the result.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Return every control to its idle value.
    task automatic idle();
        cpu_dir = 1'b1; cpu_en_hi_n = 1'b1; cpu_en_lo_n = 1'b1;
        mem_dir = 1'b0; mem_en_hi_n = 1'b1; mem_en_lo_n = 1'b1;
        swap_dir = 1'b0; swap_en_n = 1'b1; cap_strobe = 1'b0; cap_sel = 1'b0;
        cpu_in = '0; mem_in = '0; sys_in = '0;
    endtask

    // Hold reset with enables requested; outputs must stay quiet.
    task automatic t_reset();
        idle();
        rst_n = 1'b0;
        cpu_dir = 1'b0; cpu_en_hi_n = 1'b0; cpu_en_lo_n = 1'b0;
        mem_en_hi_n = 1'b0; mem_en_lo_n = 1'b0;
        sys_in = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 oe in reset", {26'd0, cpu_oe, mem_oe, sys_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cap_sel = 1'b1; mem_dir = 1'b1; mem_en_hi_n = 1'b1; mem_en_lo_n = 1'b1;
        #1;
        chk("R1 latch cleared", {24'd0, cpu_out[7:0]}, 32'h00);
        idle();
    endtask

    // Processor lane enables and direction.
    task automatic t_cpu_oe();
        idle();
        cpu_dir = 1'b0; cpu_en_hi_n = 1'b0; cpu_en_lo_n = 1'b1; #1;
        chk("R2 hi lane only", {30'd0, cpu_oe}, 32'h2);
        cpu_en_hi_n = 1'b1; cpu_en_lo_n = 1'b0; #1;
        chk("R2 lo lane only", {30'd0, cpu_oe}, 32'h1);
        cpu_dir = 1'b1; cpu_en_hi_n = 1'b0; #1;
        chk("R2 source dir", {30'd0, cpu_oe}, 32'h0);
        idle();
    endtask

    // Memory claims one lane, system supplies the other.
    task automatic t_mem_read();
        idle();
        cpu_dir = 1'b0; cpu_en_hi_n = 1'b0; cpu_en_lo_n = 1'b0;
        mem_in = 16'hBEEF; sys_in = 16'h1357;
        mem_dir = 1'b1; mem_en_hi_n = 1'b0; mem_en_lo_n = 1'b1; #1;
        chk("R3/R4 mixed lanes", {16'd0, cpu_out}, 32'hBE57);
        mem_en_lo_n = 1'b0; #1;
        chk("R3 both lanes", {16'd0, cpu_out}, 32'hBEEF);
        chk("R8 no mem drive on read", {30'd0, mem_oe}, 32'h0);
        mem_dir = 1'b0; #1;
        chk("R4 mem write dir falls to sys", {16'd0, cpu_out}, 32'h1357);
        idle();
    endtask

    // Edge capture and captured-byte selection.
    task automatic t_capture();
        idle();
        @(negedge clk);
        cpu_dir = 1'b0; cpu_en_hi_n = 1'b0; cpu_en_lo_n = 1'b0; cap_sel = 1'b1;
        sys_in = 16'hA55A; cap_strobe = 1'b1;
        @(negedge clk);
        sys_in = 16'h1234; #1;
        chk("R5/R6 captured byte", {16'd0, cpu_out}, 32'h125A);
        @(negedge clk);
        sys_in = 16'h9876; #1;
        chk("R5 strobe held high, no reload", {24'd0, cpu_out[7:0]}, 32'h5A);
        cap_strobe = 1'b0;
        @(negedge clk); #1;
        chk("R5 falling step, no reload", {24'd0, cpu_out[7:0]}, 32'h5A);
        cap_sel = 1'b0; #1;
        chk("R6 live when select low", {24'd0, cpu_out[7:0]}, 32'h76);
        idle();
    endtask

    // Read swap, using the captured low byte (capture holds 0x5A).
    task automatic t_swap_read();
        idle();
        cpu_dir = 1'b0; cpu_en_hi_n = 1'b0; cpu_en_lo_n = 1'b0;
        sys_in = 16'h44C3; swap_en_n = 1'b0; swap_dir = 1'b1; #1;
        chk("R7 live low to high lane", {16'd0, cpu_out}, 32'hC3C3);
        cap_sel = 1'b1; #1;
        chk("R7 captured low to high lane", {16'd0, cpu_out}, 32'h5A5A);
        mem_dir = 1'b1; mem_en_hi_n = 1'b0; mem_in = 16'hE100; #1;
        chk("R7 memory still wins high lane", {16'd0, cpu_out}, 32'hE15A);
        idle();
    endtask

    // Memory write path.
    task automatic t_mem_write();
        idle();
        cpu_in = 16'h6A29; mem_dir = 1'b0; mem_en_hi_n = 1'b1; mem_en_lo_n = 1'b0; #1;
        chk("R8 mem data", {16'd0, mem_out}, 32'h6A29);
        chk("R8 mem lo lane drive", {30'd0, mem_oe}, 32'h1);
        idle();
    endtask

    // System write without and with swap.
    task automatic t_sys_write();
        idle();
        cpu_in = 16'hC0DE; cpu_en_hi_n = 1'b0; cpu_en_lo_n = 1'b0; #1;
        chk("R9 sys straight data", {16'd0, sys_out}, 32'hC0DE);
        chk("R9 sys both lanes", {30'd0, sys_oe}, 32'h3);
        cpu_en_lo_n = 1'b1; swap_en_n = 1'b0; swap_dir = 1'b0; #1;
        chk("R10 swapped data", {16'd0, sys_out}, 32'hC0C0);
        chk("R10 low lane driven", {30'd0, sys_oe}, 32'h3);
        cpu_dir = 1'b0; #1;
        chk("R9 no sys drive when cpu read", {30'd0, sys_oe}, 32'h0);
        idle();
    endtask

    // Swap disabled: direction input ignored on both paths.
    task automatic t_swap_off();
        idle();
        cpu_in = 16'h7E81; cpu_en_hi_n = 1'b0; cpu_en_lo_n = 1'b1;
        swap_en_n = 1'b1; swap_dir = 1'b0; #1;
        chk("R11 write path unswapped", {16'd0, sys_out}, 32'h7E81);
        chk("R11 low lane not driven", {30'd0, sys_oe}, 32'h2);
        cpu_dir = 1'b0; cpu_en_hi_n = 1'b0; cpu_en_lo_n = 1'b0;
        sys_in = 16'h2B6D; swap_dir = 1'b1; #1;
        chk("R11 read path unswapped", {16'd0, cpu_out}, 32'h2B6D);
        idle();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        t_reset();
        t_cpu_oe();
        t_mem_read();
        t_capture();
        t_swap_read();
        t_mem_write();
        t_sys_write();
        t_swap_off();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule